// File: doc/BRIEF.md
# Thermal Status and Interrupt Controller

This block sits between a set of temperature zones and a host. Each zone hands it a one-cycle pulse whenever an already filtered temperature event has been confirmed. The block keeps one sticky status flag per zone and drives an active-low interrupt line. The line is modelled as a low data value plus an output enable, so a pad can build an open-drain driver from it. The host side is reduced to a read strobe with a register address. A read of the configuration register returns a status response on a valid-only stream and clears the flags. A read of any register releases the interrupt line.

Three plain control levels shape the behaviour. The mask level stops the line from ever sinking, which is the setting for polled use; the flags still record events. The mode level selects interrupt mode (1) or comparator mode (0). In comparator mode this block never drives the line and only keeps the flags. The shutdown level wipes all flags and the line and ignores events for as long as it is held. The response stream has no ready signal. One response leaves one cycle after each configuration read and cannot be stalled, so the host must accept it in that cycle.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset all status flags are 0, `irq_n_o` is 1, `irq_oe_o` is 0 and `rsp_vld_o` is 0.
- R2: A pulse on bit z of `evt_i` while shutdown is low sets status flag z on the next clock edge, whatever the mask and mode levels are.
- R3: A flag stays set until it is cleared. Further pulses on the same zone leave it at 1 and are not counted.
- R4: A read strobe with `rd_addr_i` equal to `CFG_ADDR` (default 1) makes `rsp_vld_o` high for one cycle, one cycle later. `rsp_status_o` then holds the flags as they were before the read, with bit z for zone z. The flags clear on the same edge.
- R5: A read strobe at any other address gives no response and leaves the flags unchanged.
- R6: An event that arrives in the same cycle as a configuration read is not in that response. Its flag is set after the read.
- R7: In interrupt mode (`irq_mode_i`=1) with the mask at 0, an event makes `irq_n_o` low and `irq_oe_o` high one cycle later.
- R8: While `irq_mask_i` is 1, `irq_oe_o` is 0 and `irq_n_o` is 1. Events seen while masked do not arm the line for later.
- R9: Any read strobe releases the line on the next edge. Flags that are still pending do not re-assert it. Only a new event does that, and an event in the same cycle as the read wins.
- R10: While `shutdown_i` is 1, all flags and the line are cleared on each edge and events are ignored.
- R11: In comparator mode (`irq_mode_i`=0) the line is never driven, but flags still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | ZONES | One pulse per confirmed event, bit z for zone z |
| rd_stb_i | input | 1 | Host register read strobe |
| rd_addr_i | input | ADDR_W | Address of the register being read |
| irq_mask_i | input | 1 | 1 keeps the interrupt line released |
| irq_mode_i | input | 1 | 1 interrupt mode, 0 comparator mode |
| shutdown_i | input | 1 | 1 clears and holds all state at zero |
| irq_n_o | output | 1 | Interrupt level, low when asserted |
| irq_oe_o | output | 1 | Enable for the open-drain pull-down |
| rsp_vld_o | output | 1 | Status response valid, no back-pressure |
| rsp_status_o | output | ZONES | Flags as they were before the clearing read |

## Verification
The bench sends an event in the very cycle of a configuration read. A design that gives the clear priority would drop that event, and one that samples after the update would put it in the wrong response. It reads a non-configuration address while flags are pending: a design that clears on every read loses the flags, and one that re-arms from pending flags pulls the line low again. It also sends events while masked and then unmasks. A design that latches masked events would assert the line at the unmask. Shutdown is held while events arrive, to catch a design that lets events through during shutdown.

// File: rtl/thermal_irq_pkg.sv
package thermal_irq_pkg;
  typedef enum logic {
    LINE_CMP = 1'b0,
    LINE_INT = 1'b1
  } line_mode_e;

  typedef struct packed {
    logic any_rd;
    logic cfg_rd;
  } rd_kind_t;
endpackage

// File: rtl/tirq_rd_decode.sv
module tirq_rd_decode
  import thermal_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1
) (
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output rd_kind_t          kind_o
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  always_comb begin
    kind_o.any_rd = rd_stb_i;
    kind_o.cfg_rd = rd_stb_i && (rd_addr_i == CFG_A);
  end
endmodule

// File: rtl/tirq_zone_flag.sv
module tirq_zone_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);
  // set beats a clearing read; shutdown beats everything
  always_ff @(posedge clk) begin
    if (!rst_n || kill_i) flag_o <= 1'b0;
    else if (set_i)       flag_o <= 1'b1;
    else if (clr_i)       flag_o <= 1'b0;
  end
endmodule

// File: rtl/tirq_line.sv
module tirq_line
  import thermal_irq_pkg::*;
#(
  parameter int ZONES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic             any_rd_i,
  input  logic [ZONES-1:0] evt_i,
  input  logic             mask_i,
  input  line_mode_e       mode_i,
  output logic             irq_n_o,
  output logic             irq_oe_o
);
  logic armed_q;
  logic fire;

  assign fire = (|evt_i) && !mask_i && (mode_i == LINE_INT);

  always_ff @(posedge clk) begin
    if (!rst_n || kill_i) armed_q <= 1'b0;
    else if (fire)        armed_q <= 1'b1;
    else if (any_rd_i)    armed_q <= 1'b0;
  end

  assign irq_oe_o = armed_q && !mask_i && (mode_i == LINE_INT);
  assign irq_n_o  = !irq_oe_o;
endmodule

// File: rtl/tirq_rsp.sv
module tirq_rsp #(
  parameter int ZONES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rd_i,
  input  logic [ZONES-1:0] snap_i,
  output logic             vld_o,
  output logic [ZONES-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= cfg_rd_i;
      if (cfg_rd_i) data_o <= snap_i;
    end
  end
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
  import thermal_irq_pkg::*;
#(
  parameter int ZONES    = 3,
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ZONES-1:0]  evt_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              irq_mask_i,
  input  logic              irq_mode_i,
  input  logic              shutdown_i,
  output logic              irq_n_o,
  output logic              irq_oe_o,
  output logic              rsp_vld_o,
  output logic [ZONES-1:0]  rsp_status_o
);
  rd_kind_t         kind;
  logic [ZONES-1:0] status_q;
  line_mode_e       mode;

  assign mode = line_mode_e'(irq_mode_i);

  tirq_rd_decode #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) dec_i (
    .rd_stb_i (rd_stb_i),
    .rd_addr_i(rd_addr_i),
    .kind_o   (kind)
  );

  for (genvar z = 0; z < ZONES; z++) begin : g_zone
    tirq_zone_flag flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .kill_i(shutdown_i),
      .clr_i (kind.cfg_rd),
      .set_i (evt_i[z]),
      .flag_o(status_q[z])
    );
  end

  tirq_line #(.ZONES(ZONES)) line_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill_i  (shutdown_i),
    .any_rd_i(kind.any_rd),
    .evt_i   (evt_i),
    .mask_i  (irq_mask_i),
    .mode_i  (mode),
    .irq_n_o (irq_n_o),
    .irq_oe_o(irq_oe_o)
  );

  tirq_rsp #(.ZONES(ZONES)) rsp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_rd_i(kind.cfg_rd),
    .snap_i  (status_q),
    .vld_o   (rsp_vld_o),
    .data_o  (rsp_status_o)
  );
endmodule

// File: rtl/thermal_irq_chk.sv
module thermal_irq_chk #(
  parameter int ZONES    = 3,
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ZONES-1:0]  evt_i,
  input logic              rd_stb_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              irq_mask_i,
  input logic              irq_mode_i,
  input logic              shutdown_i,
  input logic              irq_n_o,
  input logic              irq_oe_o,
  input logic              rsp_vld_o,
  input logic [ZONES-1:0]  rsp_status_o,
  input logic [ZONES-1:0]  status_q
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_i && evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R4
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_i && rd_stb_i && rd_addr_i == CFG_A) |=>
      (rsp_vld_o && rsp_status_o == $past(status_q) && status_q == $past(evt_i)));

  // R5
  other_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_i && rd_stb_i && rd_addr_i != CFG_A) |=>
      (!rsp_vld_o && status_q == ($past(status_q) | $past(evt_i))));

  // R7
  fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_i && evt_i != '0 && !irq_mask_i && irq_mode_i) |=>
      (irq_oe_o || irq_mask_i || !irq_mode_i));

  // R8
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask_i |-> (!irq_oe_o && irq_n_o));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && evt_i == '0) |=> !irq_oe_o);

  // R10
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (status_q == '0 && !irq_oe_o));

  // R11
  cmp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mode_i |-> !irq_oe_o);

  // R7
  line_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o != irq_oe_o);
endmodule

bind thermal_irq_ctrl thermal_irq_chk #(
  .ZONES(ZONES), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stb_i(rd_stb_i),
  .rd_addr_i(rd_addr_i), .irq_mask_i(irq_mask_i), .irq_mode_i(irq_mode_i),
  .shutdown_i(shutdown_i), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o),
  .rsp_vld_o(rsp_vld_o), .rsp_status_o(rsp_status_o), .status_q(status_q)
);

// File: tb/thermal_irq_ctrl_tb_top.sv
module thermal_irq_ctrl_tb_top;
  localparam logic [3:0] CFG  = 4'h1;
  localparam logic [3:0] OTHR = 4'h3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt_i = '0;
  logic       rd_stb_i = 1'b0;
  logic [3:0] rd_addr_i = '0;
  logic       irq_mask_i = 1'b0;
  logic       irq_mode_i = 1'b1;
  logic       shutdown_i = 1'b0;
  logic       irq_n_o, irq_oe_o, rsp_vld_o;
  logic [2:0] rsp_status_o;

  always #2 clk = ~clk;

  thermal_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stb_i(rd_stb_i),
    .rd_addr_i(rd_addr_i), .irq_mask_i(irq_mask_i), .irq_mode_i(irq_mode_i),
    .shutdown_i(shutdown_i), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o),
    .rsp_vld_o(rsp_vld_o), .rsp_status_o(rsp_status_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] m_st = '0;
  logic       m_iq = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rst_n && rsp_vld_o) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected response", 32'(rsp_vld_o), 32'd0);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(rsp_status_o), 32'(e));
      end
    end
  end

  // driver: called at a falling edge, applies one cycle of stimulus
  task automatic tick(logic [2:0] e, logic rd, logic [3:0] a, string tag);
    logic cfg_hit;
    cfg_hit = rd && (a == CFG);
    evt_i = e; rd_stb_i = rd; rd_addr_i = a;
    if (cfg_hit) begin
      exp_q.push_back(m_st);
      tag_q.push_back(tag);
    end
    if (shutdown_i) begin
      m_st = '0; m_iq = 1'b0;
    end else begin
      m_st = (cfg_hit ? 3'b000 : m_st) | e;
      m_iq = (rd ? 1'b0 : m_iq) | ((|e) && !irq_mask_i && irq_mode_i);
    end
    @(negedge clk);
    evt_i = '0; rd_stb_i = 1'b0;
    chk({tag, " line oe"}, 32'(irq_oe_o), 32'(m_iq && !irq_mask_i && irq_mode_i));
    chk({tag, " line n"}, 32'(irq_n_o), 32'(!(m_iq && !irq_mask_i && irq_mode_i)));
    chk({tag, " rsp valid"}, 32'(rsp_vld_o), 32'(cfg_hit));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_n", 32'(irq_n_o), 32'd1);
    chk("R1 oe", 32'(irq_oe_o), 32'd0);
    chk("R1 rsp", 32'(rsp_vld_o), 32'd0);
    tick(3'b000, 1'b1, CFG, "R1 flags zero");

    // R2 R7 event raises flag and line; R4 R9 cfg read reports and releases
    tick(3'b001, 1'b0, CFG, "R7 fire");
    tick(3'b000, 1'b1, CFG, "R4 read zone0");
    tick(3'b000, 1'b1, CFG, "R4 cleared");

    // R3 repeats; R5 other read keeps flags; R9 no re-arm from pending
    tick(3'b010, 1'b0, CFG, "R3 first");
    tick(3'b010, 1'b0, CFG, "R3 repeat");
    tick(3'b000, 1'b1, OTHR, "R5 other read");
    tick(3'b000, 1'b0, CFG, "R9 pending no rearm");
    tick(3'b000, 1'b1, CFG, "R3 R5 still set");

    // R6 event in same cycle as cfg read; R9 event wins over release
    tick(3'b100, 1'b0, CFG, "R6 setup");
    tick(3'b001, 1'b1, CFG, "R6 read with event");
    tick(3'b000, 1'b1, CFG, "R6 event kept");

    // R8 masked: no sink, flags still set, no late arming
    irq_mask_i = 1'b1;
    tick(3'b111, 1'b0, CFG, "R8 masked events");
    irq_mask_i = 1'b0;
    tick(3'b000, 1'b0, CFG, "R8 unmask no fire");
    tick(3'b000, 1'b1, CFG, "R2 R8 flags set while masked");

    // R11 comparator mode
    irq_mode_i = 1'b0;
    tick(3'b010, 1'b0, CFG, "R11 cmp event");
    tick(3'b000, 1'b1, CFG, "R11 flag set");
    irq_mode_i = 1'b1;

    // R10 shutdown
    tick(3'b011, 1'b0, CFG, "R10 setup fire");
    shutdown_i = 1'b1;
    tick(3'b100, 1'b0, CFG, "R10 shutdown clears");
    tick(3'b001, 1'b0, CFG, "R10 events ignored");
    shutdown_i = 1'b0;
    tick(3'b000, 1'b1, CFG, "R10 nothing kept");
    tick(3'b000, 1'b0, CFG, "R10 idle");

    chk("R4 all responses seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule